// File: doc/BRIEF.md
# Vectored Interrupt Controller with Edge/Level Capture

This block gathers a parameterised set of interrupt sources into per-source status flags. A fixed parameter bitmask chooses, for each source, whether it captures a rising transition or samples a held level. The flags are qualified by a software-written enable mask, and the result drives one request line toward a processor. A two-bit master control word gates that line: one bit turns the controller on and the other lets the request reach the hardware pin. Both bits must be set before the request can assert.

Software talks to the block over a plain 32-bit register port with a valid strobe, a write flag, a 3-bit word index, write data and read data. There is no back-pressure: every access completes in the cycle its valid strobe is sampled. Read data is registered. It shows the addressed register one clock after the read is presented and holds that value until the next read. Besides the raw flags and the qualified flags, the port offers the enable mask and an acknowledge window. It also offers atomic set and clear aliases for the enable mask, so one enable bit can change without a read-modify-write. A vector word gives the number of the lowest pending source, so an interrupt handler can dispatch with a single read.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the status, enable and master words are 0 and `irq_req` is 0. In that state a read returns 0 at every word index except the vector index 6, which returns all ones.
- R2: For a level source (bit of `EDGE_MASK` = 0), its status bit is set at every clock edge where the input is 1, whether or not the source is enabled. After an acknowledge it is set again at the next edge if the input is still 1.
- R3: For an edge source (bit of `EDGE_MASK` = 1), its status bit is set only at an edge where the input is 1 and was 0 at the previous edge. An input held high after an acknowledge leaves the bit clear.
- R4: A write to word index 3 clears each status bit whose write-data bit is 1; writing all ones clears every flag. When a new capture and an acknowledge hit the same bit in the same cycle, the bit stays set.
- R5: A write to index 2 loads the enable mask, and writing 0 there disables every source. A write to index 4 sets the enable bits marked by 1s in the data. A write to index 5 clears them. Enable bits whose data bit is 0 keep their value under indices 4 and 5.
- R6: Index 0 reads the status word and index 1 reads status AND enable, both zero-extended to 32 bits.
- R7: Index 6 reads the number of the lowest-numbered pending source, or 32'hFFFF_FFFF when nothing is pending.
- R8: Index 7 holds bit 0 (controller on) and bit 1 (hardware request allowed), loaded from write-data bits 1:0. `irq_req` is 1 exactly when at least one bit is pending and both master bits are 1.
- R9: Writes to indices 0, 1 and 6 change no state. Indices 3, 4 and 5 read as 0, and bits at or above `N_SRC` read as 0.
- R10: `bus_rdata` updates at the clock edge that samples a read (`bus_vld`=1, `bus_wr`=0), with the value the register held before that edge. At all other times it holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | N_SRC | Interrupt source inputs |
| bus_vld | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with `N_SRC` = 12 and `EDGE_MASK` = 12'hA5C. This interleaves edge sources (bits 2, 3, 4, 6, 9, 11) with level sources. Both capture variants are generated, and neighbouring sources of different kinds compete in the vector priority. The narrow width puts the zero-extended upper read bits within reach, and so is the case where a wide all-ones acknowledge word carries bits above the source count. Directed cases cover relatch after acknowledge, the same-cycle capture/acknowledge race, the enable aliases and the master gating. Seeded random traffic then mixes all of them.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFS_STATUS = 3'd0,
    OFS_PEND   = 3'd1,
    OFS_ENABLE = 3'd2,
    OFS_ACK    = 3'd3,
    OFS_SETEN  = 3'd4,
    OFS_CLREN  = 3'd5,
    OFS_VEC    = 3'd6,
    OFS_MASTER = 3'd7
  } reg_ofs_e;

  typedef struct packed {
    logic hw_gate;
    logic core_on;
  } master_t;
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
  parameter int               N_SRC     = 32,
  parameter logic [N_SRC-1:0] EDGE_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src,
  input  logic [N_SRC-1:0] ack_clr,
  output logic [N_SRC-1:0] status
);
  logic [N_SRC-1:0] hit;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src[i];
      end
      assign hit[i] = src[i] & ~prev_q;
    end else begin : g_level
      assign hit[i] = src[i];
    end

    // a new capture outranks an acknowledge in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status[i] <= 1'b0;
      else        status[i] <= hit[i] | (status[i] & ~ack_clr[i]);
    end

    p_capture_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> status[i]);
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_clr[i] && !hit[i]) |=> !status[i]);
    p_quiet_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_clr[i] && !hit[i]) |=> $stable(status[i]));
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] pend,
  output logic [REG_W-1:0] vec
);
  always_comb begin
    vec = '1;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) vec = REG_W'(i);
    end
  end

  p_vec_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |-> (vec < REG_W'(N_SRC)));
  p_vec_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pend) |-> (&vec));
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_vld,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [N_SRC-1:0]  status,
  input  logic [N_SRC-1:0]  pend,
  input  logic [REG_W-1:0]  vec,
  output logic [N_SRC-1:0]  enable,
  output master_t           master,
  output logic [N_SRC-1:0]  ack_clr,
  output logic [REG_W-1:0]  rdata
);
  reg_ofs_e         ofs;
  logic             wr_stb, rd_stb;
  logic [N_SRC-1:0] wmask;
  logic [REG_W-1:0] rd_mux;
  logic             unused_wbits;

  assign ofs          = reg_ofs_e'(bus_addr);
  assign wr_stb       = bus_vld & bus_wr;
  assign rd_stb       = bus_vld & ~bus_wr;
  assign wmask        = bus_wdata[N_SRC-1:0];
  assign unused_wbits = ^bus_wdata;
  assign ack_clr      = (wr_stb && ofs == OFS_ACK) ? wmask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '0;
    end else if (wr_stb) begin
      case (ofs)
        OFS_ENABLE: enable <= wmask;
        OFS_SETEN:  enable <= enable | wmask;
        OFS_CLREN:  enable <= enable & ~wmask;
        default:    enable <= enable;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         master <= '0;
    else if (wr_stb && ofs == OFS_MASTER) master <= master_t'(bus_wdata[1:0]);
  end

  always_comb begin
    rd_mux = '0;
    case (ofs)
      OFS_STATUS: rd_mux[N_SRC-1:0] = status;
      OFS_PEND:   rd_mux[N_SRC-1:0] = pend;
      OFS_ENABLE: rd_mux[N_SRC-1:0] = enable;
      OFS_VEC:    rd_mux = vec;
      OFS_MASTER: rd_mux[1:0] = master;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_stb) rdata <= rd_mux;
  end

  p_set_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && ofs == OFS_SETEN) |=> ((enable & $past(wmask)) == $past(wmask)));
  p_clr_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && ofs == OFS_CLREN) |=> ((enable & $past(wmask)) == '0));
  p_enable_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && (ofs == OFS_ENABLE || ofs == OFS_SETEN || ofs == OFS_CLREN))
      |=> $stable(enable));
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rdata));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int               N_SRC     = 32,
  parameter logic [N_SRC-1:0] EDGE_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_irq,
  input  logic              bus_vld,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq_req
);
  logic [N_SRC-1:0] status, enable, pend, ack_clr;
  logic [REG_W-1:0] vec;
  master_t          master;

  irqc_capture #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_capture (
    .clk(clk), .rst_n(rst_n), .src(src_irq), .ack_clr(ack_clr), .status(status)
  );

  assign pend = status & enable;

  irqc_prio #(.N_SRC(N_SRC)) u_prio (
    .clk(clk), .rst_n(rst_n), .pend(pend), .vec(vec)
  );

  irqc_regs #(.N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_vld(bus_vld), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .status(status), .pend(pend), .vec(vec),
    .enable(enable), .master(master), .ack_clr(ack_clr), .rdata(bus_rdata)
  );

  assign irq_req = (|pend) & master.core_on & master.hw_gate;

  p_req_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (master.core_on && master.hw_gate));
  p_req_needs_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !(&vec));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  localparam int             N  = 12;
  localparam logic [N-1:0]   EM = 12'hA5C;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  src;
  logic          vld, wr;
  logic [2:0]    addr;
  logic [31:0]   wdata, rdata;
  logic          req;

  always #2 clk = ~clk;

  irq_vector_ctrl #(.N_SRC(N), .EDGE_MASK(EM)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_irq(src), .bus_vld(vld), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_req(req)
  );

  logic [N-1:0] m_st, m_en, m_prev;
  logic [1:0]   m_mer;
  logic [31:0]  exp_rd;
  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] vec_of(input logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] mread(input logic [2:0] a);
    case (a)
      3'd0:    return 32'(m_st);
      3'd1:    return 32'(m_st & m_en);
      3'd2:    return 32'(m_en);
      3'd6:    return vec_of(m_st & m_en);
      3'd7:    return {30'b0, m_mer};
      default: return 32'h0;
    endcase
  endfunction

  // one bus cycle: drive at negedge, model the edge, check at next negedge
  task automatic cyc(input logic v, input logic w, input logic [2:0] a,
                     input logic [31:0] d, input logic [N-1:0] inp, input string tag);
    logic [N-1:0] hit, ack, en_n;
    logic [31:0]  rd_n;
    vld = v; wr = w; addr = a; wdata = d; src = inp;
    rd_n = (v && !w) ? mread(a) : exp_rd;            // R10
    hit  = (inp & ~EM) | (inp & ~m_prev & EM);        // R2 R3
    ack  = (v && w && a == 3'd3) ? d[N-1:0] : '0;     // R4
    en_n = m_en;
    if (v && w) begin
      case (a)
        3'd2: en_n = d[N-1:0];
        3'd4: en_n = m_en | d[N-1:0];
        3'd5: en_n = m_en & ~d[N-1:0];
        default: ;
      endcase
      if (a == 3'd7) m_mer = d[1:0];
    end
    @(posedge clk);
    #1;
    m_st = hit | (m_st & ~ack);
    m_en = en_n;
    m_prev = inp;
    exp_rd = rd_n;
    @(negedge clk);
    chk(tag, rdata, exp_rd);
    chk("R8 irq_req", {31'b0, req}, {31'b0, (|(m_st & m_en)) && (m_mer == 2'b11)});
  endtask

  task automatic rd(input logic [2:0] a, input logic [N-1:0] inp, input string tag);
    cyc(1'b1, 1'b0, a, 32'h0, inp, tag);
  endtask

  task automatic wrr(input logic [2:0] a, input logic [31:0] d, input logic [N-1:0] inp, input string tag);
    cyc(1'b1, 1'b1, a, d, inp, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [N-1:0] in_r;
    rst_n = 1'b0; src = '0; vld = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    m_st = '0; m_en = '0; m_prev = '0; m_mer = '0; exp_rd = '0;
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", rdata, 32'h0);
    chk("R1 irq in reset", {31'b0, req}, 32'h0);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rd(3'(a), '0, "R1 read after reset");

    // enable mask and aliases (R5)
    wrr(3'd7, 32'h3, '0, "R8 master");
    wrr(3'd2, 32'h00F, '0, "R5 load");
    wrr(3'd4, 32'h120, '0, "R5 set");
    rd(3'd2, '0, "R5 set alias");
    wrr(3'd5, 32'h003, '0, "R5 clr");
    rd(3'd2, '0, "R5 clear alias");
    chk("R5 enable value", exp_rd, 32'h12C);

    // level relatch (R2): source 0 is level
    rd(3'd0, 12'h001, "R2 status");
    wrr(3'd3, 32'h001, 12'h001, "R2 ack");
    rd(3'd0, 12'h001, "R2 relatch");
    chk("R2 bit0 relatched", exp_rd & 32'h1, 32'h1);
    wrr(3'd3, 32'h001, 12'h000, "R2 ack");
    rd(3'd0, 12'h000, "R2 cleared");

    // edge hold (R3): source 2 is edge
    rd(3'd0, 12'h004, "R3 status");
    wrr(3'd3, 32'h004, 12'h004, "R3 ack");
    rd(3'd0, 12'h004, "R3 held high");
    chk("R3 bit2 stays clear", exp_rd & 32'h4, 32'h0);

    // race (R4): source 3 rises during its ack
    wrr(3'd3, 32'h008, 12'h00C, "R4 race");
    rd(3'd0, 12'h00C, "R4 race status");
    chk("R4 bit3 set", exp_rd & 32'h8, 32'h8);

    // read-only and write-only (R9)
    wrr(3'd0, 32'hFFFF_FFFF, '0, "R9 ro write");
    wrr(3'd1, 32'hFFFF_FFFF, '0, "R9 ro write");
    wrr(3'd6, 32'hFFFF_FFFF, '0, "R9 ro write");
    rd(3'd0, '0, "R9 status kept");
    rd(3'd3, '0, "R9 ack reads 0");
    rd(3'd4, '0, "R9 set reads 0");
    rd(3'd5, '0, "R9 clr reads 0");

    // pending and vector (R6 R7)
    wrr(3'd3, 32'hFFFF_FFFF, '0, "R4 ack all");
    rd(3'd0, '0, "R4 all clear");
    wrr(3'd2, 32'h120, 12'h120, "R6 enable");
    rd(3'd1, 12'h120, "R6 pending");
    rd(3'd6, 12'h120, "R7 vector");
    chk("R7 lowest is 5", exp_rd, 32'd5);
    wrr(3'd7, 32'h1, 12'h120, "R8 hw gate off");
    wrr(3'd7, 32'h2, 12'h120, "R8 core off");
    wrr(3'd7, 32'h3, 12'h000, "R8 both on");
    wrr(3'd3, 32'hFFFF_FFFF, 12'h000, "R4 ack all");
    rd(3'd6, 12'h000, "R7 idle vector");
    chk("R7 none pending", exp_rd, 32'hFFFF_FFFF);
    repeat (3) cyc(1'b0, 1'b0, 3'd0, 32'h0, '0, "R10 hold");

    // seeded random traffic
    seed = $urandom(32'd7151);
    in_r = '0;
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0) in_r = in_r ^ 12'($urandom);
      if (r[4]) cyc(1'b1, r[5], r[8:6], $urandom, in_r, "R6 random");
      else      cyc(1'b0, 1'b0, 3'd0, 32'h0, in_r, "R10 random idle");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule